// File: doc/BRIEF.md
# Row Track Coordinate Resolver

The block takes, once per clock, a candidate flag and a hit bunch-crossing ID from each of the pixel rows. It reduces that set to one report per track. When a straight, stiff track crosses a band of neighbouring rows, each row in the band flags a candidate. A row is vetoed when a nearby row holds a better claim, so only the row with the earliest crossing survives. An ID of zero means no hit. Such a candidate never survives and never vetoes another row.

A survivor is packed into a word that holds its row number and its crossing ID. The word goes into a shallow queue private to that row. A round-robin arbiter moves at most one word per clock from the row queues into an output register. That register drives the periphery bus with a valid/ready handshake.

Top module: `trk_track_resolver`

## Requirements
- R1: While reset is applied and after it is released, `out_valid_o` is 0 and every bit of `ovf_o` is 0 until some row queue holds data or drops a word.
- R2: A row whose candidate flag is set but whose crossing ID is zero never produces an output word, and it never vetoes another row.
- R3: A live row (flag set, ID nonzero) is vetoed when a live row at most 7 rows away, above or below, carries a smaller ID. A live row 8 or more rows away has no effect.
- R4: When two live rows within 7 rows of each other carry the same ID, the lower row number survives and the higher one is vetoed.
- R5: A row that is itself vetoed still vetoes the rows it outranks. For example, with rows 10, 16 and 22 live at IDs 3, 5 and 7, only row 10 survives.
- R6: An output word holds the row number in bits [14:8] and the crossing ID in bits [7:0], with the default 128 rows and 8-bit IDs.
- R7: Each row queue holds up to 4 words and delivers them in arrival order. A word may enter and leave one row's queue in the same clock.
- R8: A survivor that arrives at a full row queue, with no word leaving that queue in the same clock, is discarded. The row's bit in `ovf_o` is then set and stays set until reset.
- R9: At most one row queue is granted per clock, and only a non-empty one. The search for the next grant starts at the row after the last one granted and wraps from the top row back to row 0.
- R10: While `out_valid_o` is 1 and `out_ready_i` is 0, `out_valid_o` and `out_data_o` hold their values.
- R11: The veto window is cut short at rows 0 and 127. A live edge row with no better neighbour inside the array survives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cand_i | input | 128 | Per-row candidate flag, bit r is row r |
| bxid_i | input | 1024 | Per-row crossing ID, bits [8r+7:8r] belong to row r |
| out_valid_o | output | 1 | Output word is valid |
| out_data_o | output | 15 | Output word: {row number, crossing ID} |
| out_ready_i | input | 1 | Bus accepts the output word |
| ovf_o | output | 128 | Sticky per-row queue overflow flag |

## Verification
Two things can happen to one row queue in the same clock: a new survivor is pushed in, and the arbiter pops the head toward the output register. The bench sets this up on purpose. It drives back-to-back survivors into rows that are being drained, including a queue that is already full while its head leaves. Those words are judged to arrive in row order with none lost. A full queue with a stalled output is also driven, and there exactly the words beyond the fifth must be discarded and flagged. During the random traffic, the order within each row is compared against a bench model of the veto rule.

// File: rtl/trk_res_pkg.sv
package trk_res_pkg;

  localparam int unsigned MAX_BXW = 16;

  // True when claim (bx_a,row_a) beats claim (bx_b,row_b).
  // A zero ID never beats anything; ties go to the lower row.
  function automatic logic outranks(input logic [MAX_BXW-1:0] bx_a,
                                    input int unsigned         row_a,
                                    input logic [MAX_BXW-1:0] bx_b,
                                    input int unsigned         row_b);
    if (bx_a == '0) return 1'b0;
    if (bx_a < bx_b) return 1'b1;
    return (bx_a == bx_b) && (row_a < row_b);
  endfunction

endpackage

// File: rtl/trk_veto_resolver.sv
module trk_veto_resolver #(
  parameter int unsigned ROWS = 128,
  parameter int unsigned BXW  = 8,
  parameter int unsigned WIN  = 7
) (
  input  logic [ROWS-1:0]     cand_i,
  input  logic [ROWS*BXW-1:0] bxid_i,
  output logic [ROWS-1:0]     surv_o
);
  import trk_res_pkg::*;

  logic [ROWS-1:0] live;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [2*WIN-1:0] hit;
    assign live[r] = cand_i[r] && (bxid_i[r*BXW +: BXW] != '0);
    for (genvar d = 1; d <= WIN; d++) begin : g_dist
      if (r + d < ROWS) begin : g_up
        assign hit[d-1] = live[r+d] &&
          outranks(MAX_BXW'(bxid_i[(r+d)*BXW +: BXW]), r + d,
                   MAX_BXW'(bxid_i[r*BXW +: BXW]), r);
      end else begin : g_up_edge
        assign hit[d-1] = 1'b0;
      end
      if (r - d >= 0) begin : g_dn
        assign hit[WIN+d-1] = live[r-d] &&
          outranks(MAX_BXW'(bxid_i[(r-d)*BXW +: BXW]), r - d,
                   MAX_BXW'(bxid_i[r*BXW +: BXW]), r);
      end else begin : g_dn_edge
        assign hit[WIN+d-1] = 1'b0;
      end
    end
    assign surv_o[r] = live[r] && !(|hit);
  end

endmodule

// File: rtl/trk_row_fifo.sv
module trk_row_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic         empty_o,
  output logic [W-1:0] head_o,
  output logic         drop_o,
  output logic         ovf_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;
  logic          full, accept, take;

  assign full    = (count == CW'(DEPTH));
  assign empty_o = (count == '0);
  assign take    = pop_i && !empty_o;
  assign accept  = push_i && (!full || take);
  assign drop_o  = push_i && !accept;
  assign head_o  = mem[rd_ptr];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
      ovf_o  <= 1'b0;
    end else begin
      if (accept) begin
        mem[wr_ptr] <= din_i;
        wr_ptr      <= bump(wr_ptr);
      end
      if (take) rd_ptr <= bump(rd_ptr);
      count <= count + CW'(accept) - CW'(take);
      if (drop_o) ovf_o <= 1'b1;
    end
  end

endmodule

// File: rtl/trk_rr_arb.sv
module trk_rr_arb #(
  parameter int unsigned N = 128
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [N-1:0]                        req_i,
  input  logic                                adv_i,
  output logic [N-1:0]                        gnt_o,
  output logic [((N > 1) ? $clog2(N) : 1)-1:0] idx_o,
  output logic                                any_o
);
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] ptr;

  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int unsigned i = 0; i < N; i++) begin
      int unsigned k;
      k = int'(ptr) + i;
      if (k >= N) k = k - N;
      if (!any_o && req_i[k]) begin
        any_o = 1'b1;
        idx_o = IW'(k);
      end
    end
    gnt_o = '0;
    if (any_o && adv_i) gnt_o[idx_o] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr <= '0;
    else if (adv_i && any_o)
      ptr <= (idx_o == IW'(N - 1)) ? '0 : idx_o + 1'b1;
  end

endmodule

// File: rtl/trk_track_resolver.sv
module trk_track_resolver #(
  parameter int unsigned ROWS  = 128,
  parameter int unsigned BXW   = 8,
  parameter int unsigned WIN   = 7,
  parameter int unsigned DEPTH = 4
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic [ROWS-1:0]                         cand_i,
  input  logic [ROWS*BXW-1:0]                     bxid_i,
  output logic                                    out_valid_o,
  output logic [((ROWS>1)?$clog2(ROWS):1)+BXW-1:0] out_data_o,
  input  logic                                    out_ready_i,
  output logic [ROWS-1:0]                         ovf_o
);
  localparam int unsigned RW     = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int unsigned WORD_W = RW + BXW;

  logic [ROWS-1:0]   surv_w, empty_w, drop_w, gnt_w;
  logic [WORD_W-1:0] head_w [ROWS];
  logic [RW-1:0]     gnt_idx;
  logic              any_w, load_w;

  trk_veto_resolver #(.ROWS(ROWS), .BXW(BXW), .WIN(WIN)) veto_i (
    .cand_i(cand_i), .bxid_i(bxid_i), .surv_o(surv_w)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_q
    trk_row_fifo #(.DEPTH(DEPTH), .W(WORD_W)) fifo_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .push_i (surv_w[r]),
      .din_i  ({RW'(r), bxid_i[r*BXW +: BXW]}),
      .pop_i  (gnt_w[r]),
      .empty_o(empty_w[r]),
      .head_o (head_w[r]),
      .drop_o (drop_w[r]),
      .ovf_o  (ovf_o[r])
    );
  end

  assign load_w = !out_valid_o || out_ready_i;

  trk_rr_arb #(.N(ROWS)) arb_i (
    .clk(clk), .rst_n(rst_n), .req_i(~empty_w), .adv_i(load_w),
    .gnt_o(gnt_w), .idx_o(gnt_idx), .any_o(any_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else if (load_w) begin
      out_valid_o <= any_w;
      if (any_w) out_data_o <= head_w[gnt_idx];
    end
  end

endmodule

// File: rtl/trk_res_chk.sv
module trk_res_chk #(
  parameter int unsigned ROWS   = 128,
  parameter int unsigned BXW    = 8,
  parameter int unsigned WIN    = 7,
  parameter int unsigned WORD_W = 15
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ROWS-1:0]     cand_i,
  input logic [ROWS*BXW-1:0] bxid_i,
  input logic [ROWS-1:0]     surv_w,
  input logic [ROWS-1:0]     empty_w,
  input logic [ROWS-1:0]     gnt_w,
  input logic [ROWS-1:0]     drop_w,
  input logic [ROWS-1:0]     ovf_o,
  input logic                out_valid_o,
  input logic                out_ready_i,
  input logic [WORD_W-1:0]   out_data_o
);
  function automatic logic [ROWS-1:0] above_mask(input int unsigned r);
    logic [ROWS-1:0] m;
    m = '0;
    for (int unsigned d = 1; d <= WIN; d++)
      if (r + d < ROWS) m[r+d] = 1'b1;
    return m;
  endfunction

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));

  // R9
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_w));

  // R9
  grant_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_w & empty_w) == '0);

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ovf_o & $past(ovf_o)) == $past(ovf_o));

  // R8
  drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_w != '0) |=> ((ovf_o & $past(drop_w)) == $past(drop_w)));

  for (genvar r = 0; r < ROWS; r++) begin : g_c
    // R2
    zero_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
      surv_w[r] |-> cand_i[r] && (bxid_i[r*BXW +: BXW] != '0));
    // R3
    spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      surv_w[r] |-> (surv_w & above_mask(r)) == '0);
  end

endmodule

bind trk_track_resolver trk_res_chk #(
  .ROWS(ROWS), .BXW(BXW), .WIN(WIN), .WORD_W(WORD_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cand_i(cand_i), .bxid_i(bxid_i),
  .surv_w(surv_w), .empty_w(empty_w), .gnt_w(gnt_w), .drop_w(drop_w),
  .ovf_o(ovf_o), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
  .out_data_o(out_data_o)
);

// File: tb/trk_track_resolver_tb.sv
module trk_track_resolver_tb_top;
  localparam int ROWS = 128;
  localparam int BXW  = 8;
  localparam int WW   = 15;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [ROWS-1:0]     cand = '0;
  logic [ROWS*BXW-1:0] bx = '0;
  logic                rdy = 1'b0;
  logic                out_valid;
  logic [WW-1:0]       out_data;
  logic [ROWS-1:0]     ovf;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;
  bit model_on = 1'b0;
  logic [WW-1:0] cap_q[$];
  logic [WW-1:0] exp_q[$];

  always #10 clk = ~clk;

  trk_track_resolver dut_i (
    .clk(clk), .rst_n(rst_n), .cand_i(cand), .bxid_i(bx),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_ready_i(rdy),
    .ovf_o(ovf)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // Bench view of the rule: a row keeps its claim unless a live row
  // within seven rows has an earlier crossing, or the same one lower down.
  function automatic logic [ROWS-1:0] keep_rows(input logic [ROWS-1:0] c,
                                               input logic [ROWS*BXW-1:0] b);
    logic [ROWS-1:0] k = '0;
    for (int r = 0; r < ROWS; r++) begin
      int mine = int'(b[r*BXW +: BXW]);
      bit lost = 1'b0;
      if (!c[r] || mine == 0) continue;
      for (int j = r - 7; j <= r + 7; j++) begin
        int other;
        if (j < 0 || j >= ROWS || j == r || !c[j]) continue;
        other = int'(b[j*BXW +: BXW]);
        if (other == 0) continue;
        if (other < mine || (other == mine && j < r)) lost = 1'b1;
      end
      k[r] = !lost;
    end
    return k;
  endfunction

  function automatic logic [WW-1:0] word(input int row, input int id);
    return {7'(row), 8'(id)};
  endfunction

  task automatic step(input logic [ROWS-1:0] c, input logic [ROWS*BXW-1:0] b, input logic r);
    logic [ROWS-1:0] k;
    @(negedge clk);
    cand = c; bx = b; rdy = r;
    if (out_valid && rdy) begin
      if (model_on) begin
        int hit = -1;
        for (int i = 0; i < exp_q.size(); i++)
          if (exp_q[i][14:8] == out_data[14:8]) begin hit = i; break; end
        if (hit < 0) chk(1'b0, "R7 unexpected word", out_data, 0);
        else begin
          chk(exp_q[hit] == out_data, "R7 per-row order", out_data, exp_q[hit]);
          exp_q.delete(hit);
        end
      end else cap_q.push_back(out_data);
    end
    if (model_on) begin
      k = keep_rows(c, b);
      for (int i = 0; i < ROWS; i++)
        if (k[i]) exp_q.push_back(word(i, int'(b[i*BXW +: BXW])));
    end
  endtask

  task automatic drain(input int n);
    for (int i = 0; i < n; i++) step('0, '0, 1'b1);
  endtask

  task automatic put(inout logic [ROWS-1:0] c, inout logic [ROWS*BXW-1:0] b,
                     input int row, input int id);
    c[row] = 1'b1;
    b[row*BXW +: BXW] = 8'(id);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [ROWS-1:0] c;
    logic [ROWS*BXW-1:0] b;
    logic [WW-1:0] held;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
    chk(ovf == '0, "R1 ovf in reset", ovf != '0, 0);
    @(negedge clk); rst_n = 1'b1;
    step('0, '0, 1'b0);
    chk(out_valid == 1'b0, "R1 valid after reset", out_valid, 0);

    // R9 round robin, R7 push and pop same row same cycle
    c = '0; b = '0; put(c, b, 3, 5); put(c, b, 20, 5);
    step(c, b, 1'b0);
    c = '0; b = '0; put(c, b, 3, 6); put(c, b, 20, 6);
    step(c, b, 1'b0);
    cap_q.delete(); drain(10);
    chk(cap_q.size() == 4, "R9 word count", cap_q.size(), 4);
    if (cap_q.size() == 4) begin
      chk(cap_q[0] == word(3, 5),  "R9 grant 1", cap_q[0], word(3, 5));
      chk(cap_q[1] == word(20, 5), "R9 grant 2", cap_q[1], word(20, 5));
      chk(cap_q[2] == word(3, 6),  "R9 grant 3", cap_q[2], word(3, 6));
      chk(cap_q[3] == word(20, 6), "R9 grant 4", cap_q[3], word(20, 6));
    end

    // R3 R4: 40@9, 45@4, 52@4 -> only 45 (R6 format)
    c = '0; b = '0; put(c, b, 40, 9); put(c, b, 45, 4); put(c, b, 52, 4);
    step(c, b, 1'b1);
    cap_q.delete(); drain(6);
    chk(cap_q.size() == 1, "R4 tie survivors", cap_q.size(), 1);
    if (cap_q.size() == 1) chk(cap_q[0] == word(45, 4), "R6 R3 word", cap_q[0], word(45, 4));

    // R3 distance 8: both survive
    c = '0; b = '0; put(c, b, 60, 3); put(c, b, 68, 2);
    step(c, b, 1'b1);
    cap_q.delete(); drain(6);
    chk(cap_q.size() == 2, "R3 distance eight", cap_q.size(), 2);

    // R2 zero ID neither reports nor vetoes
    c = '0; b = '0; put(c, b, 80, 0); put(c, b, 82, 7);
    step(c, b, 1'b1);
    cap_q.delete(); drain(6);
    chk(cap_q.size() == 1, "R2 zero id count", cap_q.size(), 1);
    if (cap_q.size() == 1) chk(cap_q[0] == word(82, 7), "R2 zero id word", cap_q[0], word(82, 7));

    // R5 chain 10@3, 16@5, 22@7 -> only 10
    c = '0; b = '0; put(c, b, 10, 3); put(c, b, 16, 5); put(c, b, 22, 7);
    step(c, b, 1'b1);
    cap_q.delete(); drain(6);
    chk(cap_q.size() == 1, "R5 chain count", cap_q.size(), 1);
    if (cap_q.size() == 1) chk(cap_q[0] == word(10, 3), "R5 chain word", cap_q[0], word(10, 3));

    // R11 edges: 0@4, 127@4, 121@9 -> 0 and 127
    c = '0; b = '0; put(c, b, 0, 4); put(c, b, 127, 4); put(c, b, 121, 9);
    step(c, b, 1'b1);
    cap_q.delete(); drain(6);
    chk(cap_q.size() == 2, "R11 edge count", cap_q.size(), 2);
    if (cap_q.size() == 2)
      chk((cap_q[0] == word(0, 4) && cap_q[1] == word(127, 4)) ||
          (cap_q[1] == word(0, 4) && cap_q[0] == word(127, 4)),
          "R11 edge words", {cap_q[0], cap_q[1]}, {word(0, 4), word(127, 4)});

    // R8 overflow: seven pushes into row 10 with output stalled
    for (int k = 1; k <= 7; k++) begin
      c = '0; b = '0; put(c, b, 10, k);
      step(c, b, 1'b0);
    end
    step('0, '0, 1'b0);
    held = out_data;
    step('0, '0, 1'b0);
    chk(out_valid && out_data == held, "R10 hold while stalled", out_data, held);
    chk(ovf[10] == 1'b1, "R8 ovf set", ovf[10], 1);
    chk((ovf & ~(128'd1 << 10)) == '0, "R8 other ovf clear", ovf != (128'd1 << 10), 0);
    cap_q.delete(); drain(10);
    chk(cap_q.size() == 5, "R7 R8 kept words", cap_q.size(), 5);
    for (int k = 0; k < 5 && k < cap_q.size(); k++)
      chk(cap_q[k] == word(10, k + 1), "R7 fifo order", cap_q[k], word(10, k + 1));
    chk(ovf[10] == 1'b1, "R8 ovf sticky", ovf[10], 0);

    // reset clears sticky flags
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk(ovf == '0, "R1 R8 ovf cleared", ovf != '0, 0);

    // random traffic against the bench model
    model_on = 1'b1;
    for (int t = 0; t < 800; t++) begin
      c = '0; b = '0;
      if ($urandom_range(3) == 0) begin
        int n = $urandom_range(1, 3);
        for (int i = 0; i < n; i++)
          put(c, b, $urandom_range(ROWS - 1), $urandom_range(255));
      end
      step(c, b, $urandom_range(3) != 0);
    end
    drain(300);
    chk(exp_q.size() == 0, "R7 words outstanding", exp_q.size(), 0);
    chk(ovf == '0, "R8 no random overflow", ovf != '0, 0);
    model_on = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule